// File: doc/BRIEF.md
# Frame Clock Divider with Sync-Edge Alignment

This block produces two low-rate frame clocks, nominally 8 kHz and 2 kHz, by dividing a locked high-speed clock with free-running counters. Each output has a 50% duty cycle: it is high for the first half of its count and low for the second half. A second device, or a line interface, can supply a frame-sync waveform. The block resynchronises that waveform, finds its falling edges, and reloads the dividers so that the frame clocks fall together with the sync. After the reload the dividers run freely again.

The set of dividers that a sync edge realigns depends on the sync rate. The block measures the spacing between consecutive sync falls in clock cycles. Every permitted fall realigns the fast (8 kHz) divider. The slow (2 kHz) divider is realigned only when the measured spacing matches its own period within a tolerance. A 4 kHz or 8 kHz sync therefore needs no configuration change, and it cannot displace the 2 kHz output. The `align_permit` input combines the lock, enable and qualification conditions from the surrounding logic. Alignment happens only while it is high.

Top module: `frame_clk_aligner`

## Requirements
- R1: During reset and on its release, `clk8k_o` and `clk2k_o` are high and `aligned_o` is low. The sync synchronizer resets to the high (idle) level, so the release of reset never counts as a falling edge.
- R2: With no alignment, `clk8k_o` repeats every `DIV_FAST` cycles. It is high for `DIV_FAST/2` cycles, starting on the first edge after reset, and low for the rest of the period.
- R3: With no alignment, `clk2k_o` repeats every `DIV_SLOW` cycles in the same way. It is high for `DIV_SLOW/2` cycles, then low.
- R4: The sync input is sampled by two flops, and a fall is recognised when the previous synchronized value is 1 and the current one is 0. Suppose `sync_in` is first sampled low at edge E. If `align_permit` is high at edge E+2, then `clk8k_o` is low after E+2. It stays low for `DIV_FAST - DIV_FAST/2` cycles and then resumes its free-running pattern.
- R5: The interval is the number of clock cycles between two recognised falls. `clk2k_o` is reloaded only when that interval is within `DIV_SLOW ± TOL` and the fall is permitted. A reload takes the same fixed latency as in R4 and is followed by `DIV_SLOW - DIV_SLOW/2` low cycles.
- R6: A sync whose interval is outside the tolerance window (for example `DIV_FAST` or `2*DIV_FAST` cycles) realigns `clk8k_o` only. `clk2k_o` keeps its free-running phase.
- R7: While `align_permit` is low, sync falls change neither divider.
- R8: `aligned_o` goes high on the edge that applies a permitted fall. It goes low on the first edge at which `align_permit` is sampled low, and otherwise holds its value.
- R9: The first recognised fall after reset never realigns `clk2k_o`, because no interval has been measured yet. The interval counter saturates above the tolerance window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Locked high-speed clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | External frame-sync waveform, asynchronous |
| align_permit | input | 1 | High when lock, enable and qualification all allow alignment |
| clk8k_o | output | 1 | Fast frame clock, period `DIV_FAST` cycles |
| clk2k_o | output | 1 | Slow frame clock, period `DIV_SLOW` cycles |
| aligned_o | output | 1 | Set by a permitted alignment, cleared when permission drops |

## Verification
The hardest case to reach is the edge of the tolerance window for the slow divider. It needs two sync falls whose spacing lies just inside or just outside `DIV_SLOW ± TOL`, and it must start from a slow-clock phase that makes a reload visible. The stimulus drives pairs of falls whose spacing sweeps every value across the window and a little beyond. A cycle-accurate reference computed from the requirements then shows, on the following cycles, whether the 2 kHz output jumped. Sync trains at the 8 kHz and 4 kHz spacings, and a train with permission withheld, start at deliberately odd phases so that any wrong reload changes an output.

// File: rtl/fca_pkg.sv
// Package: shared helpers for the frame clock aligner.
// Assumes: counts passed in are at least 1.
package fca_pkg;

    // Bits needed to hold values 0 .. n-1, never less than one.
    function automatic int cnt_width(input int n);
        int w;
        w = $clog2(n);
        if (w < 1) w = 1;
        return w;
    endfunction

endpackage

// File: rtl/fca_sync_edge.sv
// fca_sync_edge: brings an asynchronous sync waveform into the clock
// domain with two flops, then flags a falling edge for one cycle.
// Assumes: the idle level of the sync input is high, so every stage
// resets to 1 and reset release cannot create a false fall.
module fca_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer followed by one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A registered high followed by a low marks the fall.
    always_comb begin
        fall = prev_q & ~sync_q;
    end

endmodule

// File: rtl/fca_interval.sv
// fca_interval: counts clock cycles between recognised sync falls and
// reports, in the cycle of a fall, whether the spacing matches PERIOD
// within +/- TOL.
// Assumes: PERIOD > TOL. The counter saturates just above the window,
// so a long gap, or the very first fall after reset, never matches.
module fca_interval #(
    parameter int PERIOD = 9720,
    parameter int TOL    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    output logic match
);

    import fca_pkg::*;

    localparam int SAT_I = PERIOD + TOL + 1;
    localparam int IW    = cnt_width(SAT_I + 1);
    localparam int LO_I  = (PERIOD - TOL < 1) ? 1 : PERIOD - TOL;
    localparam int HI_I  = PERIOD + TOL;

    localparam logic [IW-1:0] SAT_V = IW'(SAT_I);
    localparam logic [IW:0]   LO_V  = (IW + 1)'(LO_I);
    localparam logic [IW:0]   HI_V  = (IW + 1)'(HI_I);

    logic [IW-1:0] gap_q;
    logic [IW:0]   gap_now;

    // Cycles elapsed since the last fall, held at the saturation value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= SAT_V;
        end else if (fall) begin
            gap_q <= '0;
        end else if (gap_q != SAT_V) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Compare the spacing that ends in this cycle against the window.
    always_comb begin
        gap_now = {1'b0, gap_q} + 1'b1;
        match   = fall && (gap_now >= LO_V) && (gap_now <= HI_V);
    end

endmodule

// File: rtl/fca_divider.sv
// fca_divider: free-running modulo-DIV counter. Its output is high while
// the count is below DIV/2, which gives a 50% duty cycle for even DIV.
// A load jumps the count to DIV/2, so the output falls on that edge.
// Assumes: DIV >= 2.
module fca_divider #(
    parameter int DIV = 2430
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    output logic                              out,
    output logic [fca_pkg::cnt_width(DIV)-1:0] cnt
);

    import fca_pkg::*;

    localparam int CW = cnt_width(DIV);
    localparam logic [CW-1:0] HALF_V = CW'(DIV / 2);
    localparam logic [CW-1:0] LAST_V = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count with wrap; an alignment load places the count at the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= HALF_V;
        end else if (cnt_q == LAST_V) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the high half of the period.
    always_comb begin
        out = (cnt_q < HALF_V);
        cnt = cnt_q;
    end

endmodule

// File: rtl/frame_clk_aligner.sv
// frame_clk_aligner: divides a locked high-speed clock into fast and slow
// frame clocks and realigns them to falls of an external sync.
// Every permitted fall reloads the fast divider. The slow divider is
// reloaded only when the measured sync spacing matches its period.
// Assumes: align_permit is synchronous to clk and already folds in lock,
// enable and qualification.
module frame_clk_aligner #(
    parameter int DIV_FAST = 2430,
    parameter int DIV_SLOW = 9720,
    parameter int TOL      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic align_permit,
    output logic clk8k_o,
    output logic clk2k_o,
    output logic aligned_o
);

    import fca_pkg::*;

    localparam int FCW = cnt_width(DIV_FAST);
    localparam int SCW = cnt_width(DIV_SLOW);

    logic           fall_pulse;
    logic           slow_match;
    logic           load_fast;
    logic           load_slow;
    logic [FCW-1:0] fast_cnt;
    logic [SCW-1:0] slow_cnt;
    logic           aligned_q;

    fca_sync_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .fall  (fall_pulse)
    );

    fca_interval #(
        .PERIOD (DIV_SLOW),
        .TOL    (TOL)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fall  (fall_pulse),
        .match (slow_match)
    );

    // Decide which dividers this cycle's fall realigns.
    always_comb begin
        load_fast = align_permit && fall_pulse;
        load_slow = align_permit && slow_match;
    end

    fca_divider #(.DIV(DIV_FAST)) u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_fast),
        .out   (clk8k_o),
        .cnt   (fast_cnt)
    );

    fca_divider #(.DIV(DIV_SLOW)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_slow),
        .out   (clk2k_o),
        .cnt   (slow_cnt)
    );

    // Aligned status: set by an applied alignment, cleared without permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned_q <= 1'b0;
        end else if (!align_permit) begin
            aligned_q <= 1'b0;
        end else if (fall_pulse) begin
            aligned_q <= 1'b1;
        end
    end

    assign aligned_o = aligned_q;

endmodule

// File: rtl/fca_checker.sv
// fca_checker: temporal properties of frame_clk_aligner, bound to it below.
// Assumes: reset is synchronous and active low.
module fca_checker #(
    parameter int DIV_FAST = 2430,
    parameter int CW       = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          permit,
    input logic          fall,
    input logic          match,
    input logic          clk_fast,
    input logic          clk_slow,
    input logic          aligned,
    input logic [CW-1:0] fast_cnt
);

    localparam logic [CW-1:0] LAST_V = CW'(DIV_FAST - 1);

    // R4: a permitted fall drives the fast clock low on the next edge.
    assert_fast_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && fall) |=> !clk_fast);

    // R5: a matching permitted fall drives the slow clock low on the next edge.
    assert_slow_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && match) |=> !clk_slow);

    // R2: the fast count stays inside its modulus.
    assert_fast_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fast_cnt <= LAST_V);

    // R2: without a load the fast count steps by one.
    assert_fast_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(permit && fall) && fast_cnt != LAST_V) |=> (fast_cnt == $past(fast_cnt) + 1'b1));

    // R7: without permission the fast count wraps normally at the end.
    assert_wrap_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!permit && fast_cnt == LAST_V) |=> (fast_cnt == '0));

    // R8: status set after a permitted fall.
    assert_aligned_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && fall) |=> aligned);

    // R8: status cleared once permission is sampled low.
    assert_aligned_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !permit |=> !aligned);

endmodule

bind frame_clk_aligner fca_checker #(
    .DIV_FAST (DIV_FAST),
    .CW       (FCW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .permit   (align_permit),
    .fall     (fall_pulse),
    .match    (slow_match),
    .clk_fast (clk8k_o),
    .clk_slow (clk2k_o),
    .aligned  (aligned_o),
    .fast_cnt (fast_cnt)
);

// File: tb/tb_frame_clk_aligner.sv
// tb_frame_clk_aligner: drives sync trains at several rates and phases, plus
// a sweep of fall spacings across the tolerance window. Every cycle it
// compares the outputs with a reference built from the requirements.
module tb_frame_clk_aligner;

    localparam int DF  = 12;
    localparam int DS  = 48;
    localparam int TL  = 2;
    localparam int HF  = DF / 2;
    localparam int HS  = DS / 2;
    localparam int SAT = DS + TL + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b1;
    logic align_permit = 1'b0;
    logic clk8k_o;
    logic clk2k_o;
    logic aligned_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference state, derived from the requirements.
    bit m_s1 = 1'b1, m_s2 = 1'b1, m_s3 = 1'b1;
    int m_gap = SAT;
    int m_cf = 0;
    int m_cs = 0;
    bit m_al = 1'b0;

    frame_clk_aligner #(.DIV_FAST(DF), .DIV_SLOW(DS), .TOL(TL)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_in      (sync_in),
        .align_permit (align_permit),
        .clk8k_o      (clk8k_o),
        .clk2k_o      (clk2k_o),
        .aligned_o    (aligned_o)
    );

    always #4 clk = ~clk;

    // Reference update on each rising edge.
    always @(posedge clk) begin
        bit f;
        bit mt;
        f  = m_s3 && !m_s2;
        mt = f && (m_gap + 1 >= DS - TL) && (m_gap + 1 <= DS + TL);
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1;
            m_gap <= SAT; m_cf <= 0; m_cs <= 0; m_al <= 1'b0;
        end else begin
            m_s1 <= sync_in; m_s2 <= m_s1; m_s3 <= m_s2;
            m_gap <= f ? 0 : ((m_gap == SAT) ? SAT : m_gap + 1);
            m_cf <= (align_permit && f) ? HF : (m_cf + 1) % DF;
            m_cs <= (align_permit && mt) ? HS : (m_cs + 1) % DS;
            m_al <= !align_permit ? 1'b0 : (f ? 1'b1 : m_al);
        end
    end

    task automatic cmp(input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    // Per-cycle comparison away from the rising edge.
    always @(negedge clk) begin
        if (chk_en) begin
            cmp("clk8k_o", clk8k_o, (m_cf < HF));
            cmp("clk2k_o", clk2k_o, (m_cs < HS));
            cmp("aligned_o", aligned_o, m_al);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Sync train: cnt periods of per cycles, low for lo cycles each.
    task automatic train(input int per, input int lo, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            sync_in = 1'b0;
            idle(lo);
            sync_in = 1'b1;
            idle(per - lo);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // R1: reset state.
        tag = "R1";
        chk_en = 1'b1;
        idle(4);
        rst_n = 1'b1;
        // R2, R3: free running, sync idle.
        tag = "R2_R3";
        idle(3 * DS + 5);
        // R7: sync trains without permission.
        tag = "R7";
        idle(7);
        train(DS, HS, 3);
        train(DF, 3, 4);
        // R9: first fall after a long gap, permitted, must not move clk2k_o.
        tag = "R9";
        idle(SAT + 13);
        align_permit = 1'b1;
        train(DS, 5, 1);
        idle(11);
        // R4, R5, R8: 2 kHz sync at an odd phase.
        tag = "R4_R5_R8";
        train(DS, HS, 4);
        idle(17);
        train(DS, 9, 3);
        // R6: 8 kHz and 4 kHz syncs leave clk2k_o free-running.
        tag = "R6";
        idle(5);
        train(DF, HF, 6);
        idle(19);
        train(2 * DF, DF, 5);
        // R5: spacing sweep across and beyond the tolerance window.
        tag = "R5";
        for (int d = DS - TL - 3; d <= DS + TL + 3; d++) begin
            idle(SAT + 3 + (d % 5));
            train(d, 2, 1);
            train(DS, 2, 1);
            idle(DS + 2);
        end
        // R8: permission drop clears status, then re-set.
        tag = "R8";
        align_permit = 1'b0;
        idle(3);
        align_permit = 1'b1;
        idle(3);
        train(DF, 4, 2);
        align_permit = 1'b0;
        idle(DS);
        chk_en = 1'b0;
        done = 1'b1;
        summary();
    end

endmodule